// File: doc/BRIEF.md
# SMBus Block Transfer Buffer Engine

This block is the data side of an SMBus host controller for multi-byte transfers. It holds a 32-byte message buffer, a byte index and the progress state of the current block or I2C block transfer. Software reaches it through single-byte register accesses. A separate transaction engine does the bus signalling. The engine pulls outgoing bytes from a read port and pushes incoming bytes back in.

There are two ways to move data. In buffered mode, software fills or empties the whole buffer through the block data register, and the index moves on with every access. In byte-by-byte mode, each byte is handed over with a byte-done handshake: software writes 1 to the byte-done status bit, and that write moves the index on and either passes the next byte or finishes the transfer. I2C block reads always run byte by byte, and their bytes come from the engine one at a time.

Top module: `smb_blk_engine`

## Requirements
- R1: After reset, status, data0, aux and the presented block byte all read 0.
- R2: Register selects are 0 status, 1 control, 2 data0 (byte count), 3 block data, 4 aux. Aux keeps only bits [1:0]: bit 1 turns on buffered mode and bit 0 is stored as the PEC enable. Status bits are 0 busy, 1 interrupt, 2 device error and 7 byte done. Control bits are 6 start, 5 last byte and [4:2] protocol (5 block, 6 I2C block read).
- R3: In buffered mode, a block data write stores the byte at the index and then adds 1 to the index. An index equal to the depth (32) stores at entry 0.
- R4: A buffered block write start with a clear address read bit requests a write (wr_req with wr_count = data0), sets interrupt and leaves busy clear, but only when the index equals data0. Otherwise it resets the index to 0 and sets device error.
- R5: When the engine reports a block read complete, its count goes into data0 and the index resets. Buffered mode then sets interrupt. Byte mode instead presents byte 0 and sets busy and byte done.
- R6: A buffered block data read presents the byte at the index and adds 1 to the index. The read that reaches data0 ends the operation and clears busy.
- R7: A byte-mode block write start stores the held byte at entry 0 and sets busy and byte done. Each byte-done clear then stores the held byte at the next index and sets byte done again. The clear that reaches data0 requests the write, sets interrupt and clears busy.
- R8: In a byte-mode block read, a byte-done clear presents the next byte and sets byte done again. If the last-byte control bit is set, the same clear presents the final byte, sets interrupt and clears busy, without setting byte done.
- R9: An I2C block read start issues i2c_req whatever the address read bit says. Each pushed byte is presented and sets byte done. A byte-done clear issues next_req. With last byte set, that request carries next_last, interrupt sets and busy clears.
- R10: A start while an operation is in progress aborts it: the index returns to 0, and an open I2C read is closed with i2c_end.
- R11: While device error is set, a start issues no request and does not set busy.
- R12: Status bits 1, 2 and 7 clear when 1 is written to them. Busy is not cleared by a status write. A byte-done clear has no effect on the transfer when no byte-mode operation is in progress.
- R13: An engine error sets device error and clears busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (R2) |
| reg_wdata | input | 8 | Register write data |
| blk_rd | input | 1 | Block data register read strobe |
| addr_read | input | 1 | Read bit of the target address |
| blk_rdata | output | 8 | Presented block data byte |
| data0 | output | 8 | Byte count register |
| status | output | 8 | Status register |
| aux | output | 2 | Auxiliary control register |
| eng_push | input | 1 | Engine delivers a received byte |
| eng_byte | input | 8 | Received byte |
| eng_done | input | 1 | Engine finished a block read |
| eng_count | input | 8 | Byte count of the finished read |
| eng_err | input | 1 | Engine reports a failed transfer |
| eng_raddr | input | 5 | Engine buffer read address |
| eng_rdata | output | 8 | Buffer byte at eng_raddr, one cycle later |
| wr_req | output | 1 | Pulse: send a block write |
| wr_count | output | 8 | Byte count of the write |
| rd_req | output | 1 | Pulse: run a block read |
| i2c_req | output | 1 | Pulse: run an I2C block read (offset, then restart to read) |
| next_req | output | 1 | Pulse: fetch the next I2C byte |
| next_last | output | 1 | The fetched byte is the last one and is NACKed |
| i2c_end | output | 1 | Pulse: close an aborted I2C read |

## Verification
The hardest state to reach is an abort in the middle of an I2C read whose index has already moved on. The index is not visible at the ports. The stimulus therefore runs two byte-done handshakes in I2C mode and then starts a buffered block write with a byte count of zero. That write is accepted only if the abort has put the index back to 0, so the wr_req pulse, together with i2c_end, shows the reset from outside. Index wrap is seen the same way: after 33 buffered writes, the engine read port shows the last byte at entry 0.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  typedef enum logic [2:0] {
    SEL_STAT = 3'd0,
    SEL_CTRL = 3'd1,
    SEL_CNT  = 3'd2,
    SEL_BLK  = 3'd3,
    SEL_AUX  = 3'd4
  } reg_sel_e;

  localparam int ST_BUSY  = 0;
  localparam int ST_INTR  = 1;
  localparam int ST_DERR  = 2;
  localparam int ST_BDONE = 7;

  localparam int CT_START = 6;
  localparam int CT_LAST  = 5;

  localparam logic [2:0] PROTO_BLOCK = 3'd5;
  localparam logic [2:0] PROTO_I2C   = 3'd6;

  localparam int AUX_BUF = 1;
endpackage

// File: rtl/smb_blk_ram.sv
module smb_blk_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re_a,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] q_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] q_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re_a) q_a <= mem[raddr_a];
    q_b <= mem[raddr_b];
  end
endmodule

// File: rtl/smb_blk_ctrl.sv
module smb_blk_ctrl
  import smb_blk_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          blk_rd,
  input  logic          addr_read,
  input  logic          eng_push,
  input  logic [DW-1:0] eng_byte,
  input  logic          eng_done,
  input  logic [DW-1:0] eng_count,
  input  logic          eng_err,
  input  logic [DW-1:0] ram_q,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic [DW-1:0] blk_rdata,
  output logic [DW-1:0] data0,
  output logic [7:0]    status,
  output logic [1:0]    aux,
  output logic          wr_req,
  output logic          rd_req,
  output logic          i2c_req,
  output logic          next_req,
  output logic          next_last,
  output logic          i2c_end
);
  logic [IW-1:0] idx_q, idx_n, eff, eff1, nxt, start_idx;
  logic [DW-1:0] data0_q, data0_n, blkdat_q, blkdat_n;
  logic [1:0]    aux_q, aux_n;
  logic [2:0]    proto_q, proto_n;
  logic busy_q, busy_n, intr_q, intr_n, derr_q, derr_n, bdone_q, bdone_n;
  logic last_q, last_n, opdone_q, opdone_n, i2c_q, i2c_n, i2cop_q, i2cop_n;
  logic wrdir_q, wrdir_n, hold_q, hold_n;
  logic wr_req_n, rd_req_n, i2c_req_n, next_req_n, next_last_n, i2c_end_n;
  logic byte_mode, rd_path;

  function automatic logic [DW-1:0] wid(input logic [IW-1:0] v);
    return {{(DW-IW){1'b0}}, v};
  endfunction

  assign eff       = (idx_q >= IW'(DEPTH)) ? '0 : idx_q;
  assign eff1      = eff + 1'b1;
  assign nxt       = (idx_q + 1'b1 >= IW'(DEPTH)) ? '0 : idx_q + 1'b1;
  assign byte_mode = !opdone_q && (i2c_q || !aux_q[AUX_BUF]);
  assign rd_path   = i2c_q || !wrdir_q;
  assign blk_rdata = hold_q ? ram_q : blkdat_q;

  always_comb begin
    idx_n = idx_q; data0_n = data0_q; blkdat_n = blkdat_q; aux_n = aux_q;
    proto_n = proto_q; busy_n = busy_q; intr_n = intr_q; derr_n = derr_q;
    bdone_n = bdone_q; last_n = last_q; opdone_n = opdone_q; i2c_n = i2c_q;
    i2cop_n = i2cop_q; wrdir_n = wrdir_q; hold_n = hold_q;
    wr_req_n = 1'b0; rd_req_n = 1'b0; i2c_req_n = 1'b0;
    next_req_n = 1'b0; next_last_n = 1'b0; i2c_end_n = 1'b0;
    ram_we = 1'b0; ram_waddr = eff[AW-1:0]; ram_wdata = reg_wdata;
    ram_re = 1'b0; ram_raddr = eff[AW-1:0];
    start_idx = idx_q;
    if (reg_wr) begin
      case (reg_sel_e'(reg_sel))
        SEL_STAT: begin
          intr_n  = intr_q  & ~reg_wdata[ST_INTR];
          derr_n  = derr_q  & ~reg_wdata[ST_DERR];
          bdone_n = bdone_q & ~reg_wdata[ST_BDONE];
          if (bdone_q && reg_wdata[ST_BDONE] && byte_mode) begin
            idx_n = nxt;
            if (!rd_path) begin
              if (wid(nxt) == data0_q) begin
                wr_req_n = 1'b1; intr_n = 1'b1; busy_n = 1'b0;
                opdone_n = 1'b1; idx_n = '0;
              end else begin
                ram_we = 1'b1; ram_waddr = nxt[AW-1:0]; ram_wdata = blk_rdata;
                bdone_n = 1'b1;
              end
            end else if (last_q) begin
              opdone_n = 1'b1; idx_n = '0; intr_n = 1'b1; busy_n = 1'b0;
              if (i2c_q) begin
                i2c_n = 1'b0; next_req_n = 1'b1; next_last_n = 1'b1;
              end else begin
                ram_re = 1'b1; ram_raddr = nxt[AW-1:0]; hold_n = 1'b1;
              end
            end else if (i2c_q) begin
              next_req_n = 1'b1;
            end else begin
              ram_re = 1'b1; ram_raddr = nxt[AW-1:0]; hold_n = 1'b1; bdone_n = 1'b1;
            end
          end
        end
        SEL_CTRL: begin
          last_n  = reg_wdata[CT_LAST];
          proto_n = reg_wdata[4:2];
          if (reg_wdata[CT_START]) begin
            if (!opdone_q) begin
              start_idx = '0; idx_n = '0; opdone_n = 1'b1;
              if (i2c_q) begin i2c_n = 1'b0; i2c_end_n = 1'b1; end
            end
            if (!derr_q) begin
              if (reg_wdata[4:2] == PROTO_BLOCK) begin
                wrdir_n = !addr_read; i2cop_n = 1'b0; idx_n = '0;
                if (addr_read) begin
                  rd_req_n = 1'b1; busy_n = 1'b1;
                end else if (aux_q[AUX_BUF]) begin
                  if (wid(start_idx) == data0_q) begin
                    wr_req_n = 1'b1; intr_n = 1'b1; busy_n = 1'b0;
                  end else begin
                    derr_n = 1'b1;
                  end
                end else begin
                  opdone_n = 1'b0; busy_n = 1'b1; bdone_n = 1'b1;
                  ram_we = 1'b1; ram_waddr = '0; ram_wdata = blk_rdata;
                end
              end else if (reg_wdata[4:2] == PROTO_I2C) begin
                i2c_req_n = 1'b1; i2c_n = 1'b1; i2cop_n = 1'b1; wrdir_n = 1'b0;
                opdone_n = 1'b0; busy_n = 1'b1; idx_n = '0;
              end
            end
          end
        end
        SEL_CNT: data0_n = reg_wdata;
        SEL_BLK: begin
          if (aux_q[AUX_BUF]) begin
            ram_we = 1'b1; idx_n = eff1;
          end else begin
            blkdat_n = reg_wdata; hold_n = 1'b0;
          end
        end
        SEL_AUX: aux_n = reg_wdata[1:0];
        default: ;
      endcase
    end else if (blk_rd) begin
      if (aux_q[AUX_BUF] && !i2c_q) begin
        ram_re = 1'b1; hold_n = 1'b1; idx_n = eff1;
        if (!opdone_q && wid(eff1) == data0_q) begin
          opdone_n = 1'b1; idx_n = '0; busy_n = 1'b0;
        end
      end
    end else if (eng_push) begin
      if (i2cop_q) begin
        blkdat_n = eng_byte; hold_n = 1'b0;
        if (!opdone_q) bdone_n = 1'b1;
      end else begin
        ram_we = 1'b1; ram_wdata = eng_byte; idx_n = eff1;
      end
    end else if (eng_done) begin
      data0_n = eng_count; idx_n = '0; opdone_n = 1'b0;
      if (aux_q[AUX_BUF]) intr_n = 1'b1;
      else begin
        ram_re = 1'b1; ram_raddr = '0; hold_n = 1'b1; busy_n = 1'b1; bdone_n = 1'b1;
      end
    end else if (eng_err) begin
      derr_n = 1'b1; busy_n = 1'b0; opdone_n = 1'b1; idx_n = '0; i2c_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0; data0_q <= '0; blkdat_q <= '0; aux_q <= '0; proto_q <= '0;
      busy_q <= 1'b0; intr_q <= 1'b0; derr_q <= 1'b0; bdone_q <= 1'b0;
      last_q <= 1'b0; opdone_q <= 1'b1; i2c_q <= 1'b0; i2cop_q <= 1'b0;
      wrdir_q <= 1'b0; hold_q <= 1'b0;
      wr_req <= 1'b0; rd_req <= 1'b0; i2c_req <= 1'b0;
      next_req <= 1'b0; next_last <= 1'b0; i2c_end <= 1'b0;
    end else begin
      idx_q <= idx_n; data0_q <= data0_n; blkdat_q <= blkdat_n; aux_q <= aux_n;
      proto_q <= proto_n; busy_q <= busy_n; intr_q <= intr_n; derr_q <= derr_n;
      bdone_q <= bdone_n; last_q <= last_n; opdone_q <= opdone_n; i2c_q <= i2c_n;
      i2cop_q <= i2cop_n; wrdir_q <= wrdir_n; hold_q <= hold_n;
      wr_req <= wr_req_n; rd_req <= rd_req_n; i2c_req <= i2c_req_n;
      next_req <= next_req_n; next_last <= next_last_n; i2c_end <= i2c_end_n;
    end
  end

  assign data0  = data0_q;
  assign aux    = aux_q;
  assign status = {bdone_q, 4'b0, derr_q, intr_q, busy_q};

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (rst) idx_q <= IW'(DEPTH));
  // R4
  wr_idle_chk: assert property (@(posedge clk) disable iff (rst) wr_req |-> !busy_q);
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy_q) |-> opdone_q);
  // R9
  next_src_chk: assert property (@(posedge clk) disable iff (rst) next_req |-> $past(i2c_q));
  // R10
  end_src_chk: assert property (@(posedge clk) disable iff (rst) i2c_end |-> $past(i2c_q) && !i2c_q);
  // R11
  req_one_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({wr_req, rd_req, i2c_req}));
endmodule

// File: rtl/smb_blk_engine.sv
module smb_blk_engine #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          blk_rd,
  input  logic          addr_read,
  output logic [DW-1:0] blk_rdata,
  output logic [DW-1:0] data0,
  output logic [7:0]    status,
  output logic [1:0]    aux,
  input  logic          eng_push,
  input  logic [DW-1:0] eng_byte,
  input  logic          eng_done,
  input  logic [DW-1:0] eng_count,
  input  logic          eng_err,
  input  logic [AW-1:0] eng_raddr,
  output logic [DW-1:0] eng_rdata,
  output logic          wr_req,
  output logic [DW-1:0] wr_count,
  output logic          rd_req,
  output logic          i2c_req,
  output logic          next_req,
  output logic          next_last,
  output logic          i2c_end
);
  logic          ram_we, ram_re;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0] ram_wdata, ram_q;

  smb_blk_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re_a(ram_re), .raddr_a(ram_raddr), .q_a(ram_q),
    .raddr_b(eng_raddr), .q_b(eng_rdata)
  );

  smb_blk_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .blk_rd(blk_rd), .addr_read(addr_read), .eng_push(eng_push), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_count(eng_count), .eng_err(eng_err), .ram_q(ram_q),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .blk_rdata(blk_rdata), .data0(data0),
    .status(status), .aux(aux), .wr_req(wr_req), .rd_req(rd_req), .i2c_req(i2c_req),
    .next_req(next_req), .next_last(next_last), .i2c_end(i2c_end)
  );

  assign wr_count = data0;
endmodule

// File: tb/test_smb_blk_engine.sv
module test_smb_blk_engine;
  localparam int PERIOD = 10;
  localparam logic [2:0] S_STAT = 0, S_CTRL = 1, S_CNT = 2, S_BLK = 3, S_AUX = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, blk_rd = 0, addr_read = 0, eng_push = 0, eng_done = 0, eng_err = 0;
  logic [2:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, eng_byte = 0, eng_count = 0;
  logic [4:0] eng_raddr = 0;
  logic [7:0] blk_rdata, data0, status, eng_rdata, wr_count;
  logic [1:0] aux;
  logic wr_req, rd_req, i2c_req, next_req, next_last, i2c_end;
  int total = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  smb_blk_engine i_smb_blk_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .blk_rd(blk_rd), .addr_read(addr_read), .blk_rdata(blk_rdata), .data0(data0),
    .status(status), .aux(aux), .eng_push(eng_push), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_count(eng_count), .eng_err(eng_err),
    .eng_raddr(eng_raddr), .eng_rdata(eng_rdata), .wr_req(wr_req), .wr_count(wr_count),
    .rd_req(rd_req), .i2c_req(i2c_req), .next_req(next_req), .next_last(next_last),
    .i2c_end(i2c_end)
  );

  task automatic ck(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdb();
    @(negedge clk); blk_rd = 1;
    @(negedge clk); blk_rd = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); eng_push = 1; eng_byte = b;
    @(negedge clk); eng_push = 0;
  endtask

  task automatic done(input logic [7:0] c);
    @(negedge clk); eng_done = 1; eng_count = c;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic peek(input string tag, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); eng_raddr = a;
    @(negedge clk); ck(tag, eng_rdata, exp);
  endtask

  task automatic t_reset();
    ck("R1 status", status, 8'h00);
    ck("R1 data0", data0, 8'h00);
    ck("R1 aux", {6'b0, aux}, 8'h00);
    ck("R1 blk_rdata", blk_rdata, 8'h00);
  endtask

  task automatic t_aux();
    acc(S_AUX, 8'hFF);
    ck("R2 aux mask", {6'b0, aux}, 8'h03);
  endtask

  task automatic t_bufwrite();
    acc(S_AUX, 8'h02); acc(S_CNT, 8'd3); addr_read = 0;
    acc(S_BLK, 8'hA1); acc(S_BLK, 8'hA2); acc(S_BLK, 8'hA3);
    peek("R3 store0", 0, 8'hA1); peek("R3 store2", 2, 8'hA3);
    acc(S_CTRL, 8'h54);
    ck("R4 wr_req", {7'b0, wr_req}, 8'h01);
    ck("R4 wr_count", wr_count, 8'd3);
    ck("R4 status", status, 8'h02);
    acc(S_STAT, 8'h02);
    ck("R12 intr clear", status, 8'h00);
  endtask

  task automatic t_mismatch();
    acc(S_CNT, 8'd2); acc(S_BLK, 8'hB1);
    acc(S_CTRL, 8'h54);
    ck("R4 no wr_req", {7'b0, wr_req}, 8'h00);
    ck("R4 derr", status, 8'h04);
    acc(S_BLK, 8'hC5);
    peek("R4 index reset", 0, 8'hC5);
    acc(S_STAT, 8'h04);
    ck("R12 derr clear", status, 8'h00);
  endtask

  task automatic t_wrap();
    acc(S_CNT, 8'd40); acc(S_CTRL, 8'h54); acc(S_STAT, 8'h04);
    for (int i = 0; i < 32; i++) acc(S_BLK, 8'h40 + 8'(i));
    acc(S_BLK, 8'hEE);
    peek("R3 wrap to 0", 0, 8'hEE);
    peek("R3 entry1", 1, 8'h41);
    peek("R3 entry31", 31, 8'h5F);
    acc(S_CTRL, 8'h54); acc(S_STAT, 8'h04);
  endtask

  task automatic t_bufread();
    acc(S_AUX, 8'h02); addr_read = 1;
    acc(S_CTRL, 8'h54);
    ck("R5 rd_req", {7'b0, rd_req}, 8'h01);
    push(8'h11); push(8'h22); push(8'h33);
    done(8'd3);
    ck("R5 data0", data0, 8'd3);
    ck("R5 buffered status", status, 8'h03);
    rdb(); ck("R6 byte0", blk_rdata, 8'h11); ck("R6 busy held", status, 8'h03);
    rdb(); ck("R6 byte1", blk_rdata, 8'h22);
    rdb(); ck("R6 byte2", blk_rdata, 8'h33); ck("R6 busy clear", status, 8'h02);
    acc(S_STAT, 8'h02);
  endtask

  task automatic t_bytewrite();
    acc(S_AUX, 8'h00); acc(S_CNT, 8'd3); addr_read = 0;
    acc(S_BLK, 8'h71);
    acc(S_CTRL, 8'h54);
    ck("R7 start status", status, 8'h81);
    peek("R7 entry0", 0, 8'h71);
    acc(S_BLK, 8'h72); acc(S_STAT, 8'h80);
    ck("R7 bdone again", status, 8'h81);
    peek("R7 entry1", 1, 8'h72);
    acc(S_BLK, 8'h73); acc(S_STAT, 8'h80);
    peek("R7 entry2", 2, 8'h73);
    acc(S_STAT, 8'h80);
    ck("R7 wr_req", {7'b0, wr_req}, 8'h01);
    ck("R7 wr_count", wr_count, 8'd3);
    ck("R7 end status", status, 8'h02);
    acc(S_STAT, 8'h02);
  endtask

  task automatic t_byteread();
    acc(S_AUX, 8'h00); addr_read = 1;
    acc(S_CTRL, 8'h54);
    ck("R5 rd_req byte", {7'b0, rd_req}, 8'h01);
    for (int i = 0; i < 5; i++) push(8'h90 + 8'(i));
    done(8'd5);
    ck("R5 data0 byte", data0, 8'd5);
    ck("R5 byte status", status, 8'h81);
    ck("R5 byte0 shown", blk_rdata, 8'h90);
    acc(S_STAT, 8'h80);
    ck("R8 next byte", blk_rdata, 8'h91);
    ck("R8 bdone again", status, 8'h81);
    acc(S_CTRL, 8'h34);
    acc(S_STAT, 8'h80);
    ck("R8 final byte", blk_rdata, 8'h92);
    ck("R8 end status", status, 8'h02);
    acc(S_STAT, 8'h82);
    ck("R12 no effect", blk_rdata, 8'h92);
    ck("R12 no effect status", status, 8'h00);
  endtask

  task automatic t_i2c();
    acc(S_AUX, 8'h02); addr_read = 0;
    acc(S_CTRL, 8'h58);
    ck("R9 i2c_req", {7'b0, i2c_req}, 8'h01);
    ck("R9 no rd_req", {7'b0, rd_req}, 8'h00);
    ck("R9 busy", status, 8'h01);
    push(8'hA0);
    ck("R9 byte shown", blk_rdata, 8'hA0); ck("R9 bdone", status, 8'h81);
    rdb(); ck("R9 held on read", blk_rdata, 8'hA0);
    acc(S_STAT, 8'h80);
    ck("R9 next_req", {6'b0, next_req, next_last}, 8'h02);
    ck("R9 waiting", status, 8'h01);
    push(8'hA1); ck("R9 byte1", blk_rdata, 8'hA1);
    acc(S_CTRL, 8'h38); acc(S_STAT, 8'h80);
    ck("R9 last fetch", {6'b0, next_req, next_last}, 8'h03);
    ck("R9 end status", status, 8'h02);
    push(8'hA2);
    ck("R9 final byte", blk_rdata, 8'hA2); ck("R9 no bdone", status, 8'h02);
    acc(S_STAT, 8'h02);
  endtask

  task automatic t_abort();
    acc(S_AUX, 8'h02); acc(S_CNT, 8'd0); addr_read = 0;
    acc(S_CTRL, 8'h58);
    push(8'hB0); acc(S_STAT, 8'h80);
    push(8'hB1); acc(S_STAT, 8'h80);
    acc(S_CTRL, 8'h54);
    ck("R10 i2c_end", {7'b0, i2c_end}, 8'h01);
    ck("R10 index reset", {7'b0, wr_req}, 8'h01);
    ck("R10 status", status, 8'h02);
    acc(S_STAT, 8'h02);
  endtask

  task automatic t_derr();
    acc(S_CNT, 8'd5); addr_read = 0; acc(S_CTRL, 8'h54);
    ck("R11 derr set", status, 8'h04);
    addr_read = 1; acc(S_CTRL, 8'h54);
    ck("R11 no rd_req", {7'b0, rd_req}, 8'h00);
    ck("R11 no busy", status, 8'h04);
    acc(S_STAT, 8'h04);
  endtask

  task automatic t_err();
    addr_read = 1; acc(S_CTRL, 8'h54);
    ck("R13 busy", status, 8'h01);
    acc(S_STAT, 8'hFF);
    ck("R12 busy kept", status, 8'h01);
    @(negedge clk); eng_err = 1;
    @(negedge clk); eng_err = 0;
    ck("R13 error", status, 8'h04);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_aux(); t_bufwrite(); t_mismatch(); t_wrap(); t_bufread();
    t_bytewrite(); t_byteread(); t_i2c(); t_abort(); t_derr(); t_err();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule